// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog. It counts down a 7-bit value on a slow tick and asks for a system reset when software fails to service it in time. Servicing too early also counts as a failure. The tick comes from two dividers in series. The first is a fixed divider on the peripheral clock. The second is a programmable divider of 1, 2, 4 or 8. A timeout spans (count & 0x3F) + 1 ticks. It ends when bit 6 of the count falls, which is the step from 0x40 to 0x3F.

Software works through one write port with three registers. The count register reloads the counter, and the same write may set a one-way enable bit. The configuration register holds the window value, the prescaler select and the early-warning interrupt enable. The status register clears the early-warning flag. A debug-freeze input stops the dividers and the counter in place.

Each counter write restarts both dividers, so software can predict exactly when the next tick lands.

Top module: `win_watchdog`

## Requirements
- R1: After reset the block is disabled, the count reads 0x7F, the window is 0x7F, the prescaler select is 0, and the reset request, interrupt and wake flag are all low.
- R2: While enabled, the count drops by one every FIXED_DIV * 2^n clock cycles. The value n comes from bits [8:7] of a configuration write (address 1). A count write (address 0) restarts both dividers, so the first decrement comes exactly one full period after the write edge.
- R3: When the enabled count steps from 0x40 to 0x3F, rst_req_o is high for exactly one cycle, starting at the edge where count_o becomes 0x3F.
- R4: While enabled, a count write whose bits [6:0] are below 0x40 raises rst_req_o for one cycle, starting at the write edge. The value is still loaded. A write of 0x40 or above raises no request.
- R5: While enabled, a count write made while the current count is above the window (bits [6:0] of a configuration write) raises rst_req_o for one cycle and still loads the value. A write made while the count is at or below the window only reloads the count.
- R6: Setting bit 7 of a count write turns the block on. No later write turns it off: a count write with bit 7 clear leaves the counter decrementing.
- R7: While disabled, the count only changes through count writes, and no write raises rst_req_o.
- R8: The wake flag sets at the edge where a tick brings the count to 0x40. irq_o equals the flag AND the interrupt enable (bit 9 of a configuration write). Writing 1 to bit 0 of address 2 clears the flag.
- R9: While dbg_freeze is high, both dividers and the count hold. When it drops, counting resumes from the held divider state, so the pending tick is late by exactly the number of frozen cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 configuration, 2 status, 3 unused |
| wr_data | input | 10 | Write data |
| dbg_freeze | input | 1 | Holds dividers and count while high |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |
| count_o | output | 7 | Current count value |
| wake_flag_o | output | 1 | Early-warning flag |

## Verification
Register writes take effect at the write edge itself. This covers a loaded count, a write-triggered reset request and a cleared flag, all of which are visible on the outputs right after that edge. A tick-driven change appears P = FIXED_DIV * 2^n cycles after the last count write, plus one cycle for each frozen cycle. A rollover reset request lasts only the single cycle after its tick edge. The driver works out each result's due cycle from these rules and queues it, and the monitor compares the result in that cycle only, midway between edges. The checks include the cycle just before each expected tick, to catch a change that comes one cycle early.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Shared widths, field positions, register selects and reset values for the
// windowed watchdog. Assumes a 7-bit counter whose bit 6 marks the live range.
package wdt_pkg;

    localparam int CNT_W   = 7;
    localparam int PSC_W   = 2;
    localparam int WDATA_W = 10;

    // Write data field positions
    localparam int EN_BIT  = 7;   // count register: one-way enable
    localparam int PSC_LSB = 7;   // config register: prescaler select [8:7]
    localparam int IE_BIT  = 9;   // config register: interrupt enable
    localparam int CLR_BIT = 0;   // status register: flag clear

    typedef logic [CNT_W-1:0] wd_cnt_t;

    localparam wd_cnt_t CNT_FLOOR   = 7'h40;
    localparam wd_cnt_t CNT_WAKE    = 7'h41;
    localparam wd_cnt_t CNT_RST_VAL = 7'h7F;
    localparam wd_cnt_t WIN_RST_VAL = 7'h7F;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_CONFIG = 2'd1,
        REG_STATUS = 2'd2
    } wd_reg_e;

endpackage

// File: rtl/wdt_regs.sv
// Module wdt_regs
// Decodes the write port into strobes and holds the configuration state:
// one-way enable, window value, prescaler select and interrupt enable.
// Assumes single-cycle write strobes; address 3 is ignored.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [WDATA_W-1:0]   wr_data,
    output logic                 cnt_wr,
    output wd_cnt_t              cnt_wdata,
    output logic                 flag_clr,
    output logic                 en_q,
    output wd_cnt_t              win_q,
    output logic [PSC_W-1:0]     psc_q,
    output logic                 ie_q
);

    logic cfg_wr;
    logic stat_wr;

    // Address decode into per-register strobes
    always_comb begin
        cnt_wr    = wr_en && (wr_addr == REG_COUNT);
        cfg_wr    = wr_en && (wr_addr == REG_CONFIG);
        stat_wr   = wr_en && (wr_addr == REG_STATUS);
        cnt_wdata = wr_data[CNT_W-1:0];
        flag_clr  = stat_wr && wr_data[CLR_BIT];
    end

    // Enable can only be set; only reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cnt_wr && wr_data[EN_BIT]) begin
            en_q <= 1'b1;
        end
    end

    // Configuration register: window, prescaler, interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= WIN_RST_VAL;
            psc_q <= '0;
            ie_q  <= 1'b0;
        end else if (cfg_wr) begin
            win_q <= wr_data[CNT_W-1:0];
            psc_q <= wr_data[PSC_LSB +: PSC_W];
            ie_q  <= wr_data[IE_BIT];
        end
    end

    assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

endmodule

// File: rtl/wdt_ticker.sv
// Module wdt_ticker
// Two-stage tick source: a fixed divide-by-FIXED_DIV stage feeding a
// programmable 2^n stage. Emits a one-cycle tick on the last clock of each
// period. Holds while run is low; restart zeroes both stages.
// Assumes FIXED_DIV >= 2.
module wdt_ticker
    import wdt_pkg::*;
#(
    parameter int FIXED_DIV = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    localparam int FDIV_W    = $clog2(FIXED_DIV);
    localparam int PRE_STEPS = 1 << ((1 << PSC_W) - 1);
    localparam int PRE_W     = $clog2(PRE_STEPS);

    logic [FDIV_W-1:0] fdiv_q;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  pre_lim;
    logic              fdiv_last;
    logic              pre_last;

    // Stage limits and tick decode
    always_comb begin
        pre_lim   = PRE_W'((1 << psc) - 1);
        fdiv_last = (fdiv_q == FDIV_W'(FIXED_DIV - 1));
        pre_last  = (pre_q >= pre_lim);
        tick      = run && fdiv_last && pre_last;
    end

    // Divider stages: restart wins, then advance while running
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fdiv_q <= '0;
            pre_q  <= '0;
        end else if (run) begin
            if (fdiv_last) begin
                fdiv_q <= '0;
                pre_q  <= pre_last ? '0 : pre_q + 1'b1;
            end else begin
                fdiv_q <= fdiv_q + 1'b1;
            end
        end
    end

    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (fdiv_q == '0) && (pre_q == '0));

    assert_hold_when_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(fdiv_q) && $stable(pre_q)));

endmodule

// File: rtl/wdt_core.sv
// Module wdt_core
// The down-counter with window and floor checks. Produces a registered
// one-cycle reset request and the early-warning flag.
// Assumes tick is only ever high while the block is enabled.
// A count write takes priority over a tick in the same cycle.
module wdt_core
    import wdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_q,
    input  logic    tick,
    input  logic    cnt_wr,
    input  wd_cnt_t cnt_wdata,
    input  wd_cnt_t win_q,
    input  logic    flag_clr,
    input  logic    ie_q,
    output wd_cnt_t cnt_q,
    output logic    rst_req_q,
    output logic    flag_q,
    output logic    irq_o
);

    wd_cnt_t cnt_dec;
    logic    roll;
    logic    low_wr;
    logic    early_wr;
    logic    wake_set;

    // Failure and wake conditions for this cycle
    always_comb begin
        cnt_dec  = cnt_q - wd_cnt_t'(1);
        roll     = tick && !cnt_wr && cnt_q[CNT_W-1] && !cnt_dec[CNT_W-1];
        low_wr   = cnt_wr && en_q && !cnt_wdata[CNT_W-1];
        early_wr = cnt_wr && en_q && (cnt_q > win_q);
        wake_set = tick && !cnt_wr && (cnt_dec == CNT_FLOOR);
        irq_o    = flag_q && ie_q;
    end

    // Counter: reload on write, else step down on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST_VAL;
        end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (tick) begin
            cnt_q <= cnt_dec;
        end
    end

    // Reset request: one cycle per failing event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= roll || low_wr || early_wr;
        end
    end

    // Early-warning flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= wake_set || (flag_q && !flag_clr);
        end
    end

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt_q == wd_cnt_t'($past(cnt_q) - 1)));

    assert_rollover_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == CNT_FLOOR) |=> rst_req_q);

    assert_low_write_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && en_q && (cnt_wdata < CNT_FLOOR)) |=> rst_req_q);

    assert_early_refresh_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && en_q && (cnt_q > win_q)) |=> rst_req_q);

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !rst_req_q);

    assert_wake_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == CNT_WAKE) |=> flag_q);

endmodule

// File: rtl/win_watchdog.sv
// Module win_watchdog
// Top of the windowed watchdog: register decode, tick source and counter
// core. Assumes a free-running peripheral clock and synchronous reset.
module win_watchdog
    import wdt_pkg::*;
#(
    parameter int FIXED_DIV = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               dbg_freeze,
    output logic               rst_req_o,
    output logic               irq_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               wake_flag_o
);

    logic             cnt_wr;
    wd_cnt_t          cnt_wdata;
    logic             flag_clr;
    logic             en_q;
    wd_cnt_t          win_q;
    logic [PSC_W-1:0] psc_q;
    logic             ie_q;
    logic             run;
    logic             tick;
    wd_cnt_t          cnt_q;

    // Dividers advance only while enabled and not frozen
    always_comb begin
        run     = en_q && !dbg_freeze;
        count_o = cnt_q;
    end

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .flag_clr  (flag_clr),
        .en_q      (en_q),
        .win_q     (win_q),
        .psc_q     (psc_q),
        .ie_q      (ie_q)
    );

    wdt_ticker #(.FIXED_DIV(FIXED_DIV)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cnt_wr),
        .psc     (psc_q),
        .tick    (tick)
    );

    wdt_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_q      (en_q),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .win_q     (win_q),
        .flag_clr  (flag_clr),
        .ie_q      (ie_q),
        .cnt_q     (cnt_q),
        .rst_req_q (rst_req_o),
        .flag_q    (wake_flag_o),
        .irq_o     (irq_o)
    );

endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected port values with their due
// cycle, and the monitor compares them in that cycle, 1 ns after the falling edge.
module win_watchdog_tb;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [9:0] wr_data = '0;
    logic       dbg_freeze = 1'b0;
    logic       rst_req_o;
    logic       irq_o;
    logic [6:0] count_o;
    logic       wake_flag_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    cnt;
        int    rst;
        int    irq;
        int    flg;
        string tag;
    } exp_t;

    exp_t sb[$];

    win_watchdog #(.FIXED_DIV(DIV)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .dbg_freeze  (dbg_freeze),
        .rst_req_o   (rst_req_o),
        .irq_o       (irq_o),
        .count_o     (count_o),
        .wake_flag_o (wake_flag_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expectation delta cycles from now (-1 = don't care)
    task automatic expect_at(input int delta, input int c, input int r,
                             input int i, input int f, input string tag);
        exp_t e;
        e.due = cyc + delta; e.cnt = c; e.rst = r; e.irq = i; e.flg = f; e.tag = tag;
        sb.push_back(e);
    endtask

    // One register write; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every item due in this cycle
    always begin
        @(negedge clk);
        #1;
        for (int k = sb.size() - 1; k >= 0; k--) begin
            if (sb[k].due <= cyc) begin
                bit bad;
                bad = (sb[k].due < cyc)
                   || (sb[k].cnt >= 0 && int'(count_o) != sb[k].cnt)
                   || (sb[k].rst >= 0 && int'(rst_req_o) != sb[k].rst)
                   || (sb[k].irq >= 0 && int'(irq_o) != sb[k].irq)
                   || (sb[k].flg >= 0 && int'(wake_flag_o) != sb[k].flg);
                n_checks++;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s @%0d: cnt=%0h/%0h rst=%0d/%0d irq=%0d/%0d flag=%0d/%0d (actual/expected)",
                             sb[k].tag, cyc, count_o, sb[k].cnt, rst_req_o, sb[k].rst,
                             irq_o, sb[k].irq, wake_flag_o, sb[k].flg);
                end
                sb.delete(k);
            end
        end
    end

    // Watchdog for a hung run
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int we;
        idle(4);
        rst_n = 1'b1;
        expect_at(0, 'h7F, 0, 0, 0, "R1 reset state");
        expect_at(10, 'h7F, 0, 0, 0, "R7 disabled idle hold");
        idle(11);

        // R7: a low value written while disabled neither resets nor counts
        wr(2'd0, 10'h010);
        expect_at(0, 'h10, 0, 0, 0, "R7 disabled low write");
        expect_at(8, 'h10, 0, -1, -1, "R7 disabled no decrement");
        idle(9);

        // R6/R2/R8/R3: enable with 0x43, prescaler 0, irq on
        wr(2'd1, 10'h27F);
        wr(2'd0, 10'h0C3);
        expect_at(0, 'h43, 0, 0, 0, "R6 enable load");
        expect_at(3, 'h43, 0, 0, 0, "R2 no tick before period");
        expect_at(4, 'h42, 0, 0, 0, "R2 first tick");
        expect_at(8, 'h41, 0, 0, 0, "R2 second tick");
        expect_at(12, 'h40, 0, 1, 1, "R8 flag and irq at 0x40");
        expect_at(15, 'h40, 0, 1, 1, "R3 no early request");
        expect_at(16, 'h3F, 1, 1, 1, "R3 rollover request");
        expect_at(17, 'h3F, 0, 1, 1, "R3 request single cycle");
        idle(18);

        // R8: write-one clears the flag
        wr(2'd2, 10'h001);
        expect_at(0, -1, -1, 0, 0, "R8 flag clear");

        // R6: bit 7 clear keeps it enabled; R5 in-window reload
        wr(2'd0, 10'h07F);
        expect_at(0, 'h7F, 0, 0, 0, "R5 in-window reload");
        expect_at(4, 'h7E, 0, -1, -1, "R6 enable stays set");
        idle(5);

        // R5: refresh while above the window
        wr(2'd1, 10'h250);
        wr(2'd0, 10'h07F);
        expect_at(0, 'h7F, 1, -1, -1, "R5 early refresh request");
        expect_at(1, 'h7F, 0, -1, -1, "R5 request single cycle");
        we = cyc;
        while (cyc < we + 190) @(negedge clk);
        wr(2'd0, 10'h060);
        expect_at(0, 'h60, 0, -1, -1, "R5 refresh at window boundary");

        // R4: low write while enabled
        wr(2'd1, 10'h27F);
        wr(2'd0, 10'h020);
        expect_at(0, 'h20, 1, -1, -1, "R4 low write request");
        wr(2'd0, 10'h07F);
        expect_at(0, 'h7F, 0, -1, -1, "R4 valid reload no request");

        // R2: prescaler select 3 -> period 8*DIV
        wr(2'd1, 10'h3FF);
        wr(2'd0, 10'h07F);
        expect_at(31, 'h7F, 0, -1, -1, "R2 psc3 hold");
        expect_at(32, 'h7E, 0, -1, -1, "R2 psc3 first tick");
        expect_at(64, 'h7D, 0, -1, -1, "R2 psc3 second tick");
        idle(65);

        // R9: freeze for 10 cycles right after a reload
        wr(2'd1, 10'h27F);
        wr(2'd0, 10'h07F);
        dbg_freeze = 1'b1;
        expect_at(10, 'h7F, 0, -1, -1, "R9 frozen count holds");
        idle(10);
        dbg_freeze = 1'b0;
        expect_at(3, 'h7F, 0, -1, -1, "R9 tick delayed by freeze");
        expect_at(4, 'h7E, 0, -1, -1, "R9 resumed tick");
        idle(5);

        // R8: flag with interrupt masked, then R3 again
        wr(2'd2, 10'h001);
        wr(2'd1, 10'h07F);
        wr(2'd0, 10'h041);
        expect_at(0, 'h41, 0, 0, 0, "R8 cleared before wake");
        expect_at(4, 'h40, 0, 0, 1, "R8 irq masked");
        expect_at(8, 'h3F, 1, 0, 1, "R3 second rollover");
        idle(10);

        done = 1'b1;
        foreach (sb[k]) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s: never checked, actual=pending expected=due %0d", sb[k].tag, sb[k].due);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule